// File: doc/BRIEF.md
# Serial Character Receiver with Error-Tagged Receive Queue

This block receives asynchronous serial characters on a single line input. A one-cycle pulse from an external source arrives sixteen times per bit period. The block uses it to find a start edge, confirm the start bit half a bit later, and then sample eight data bits, least significant first. It can also sample an optional parity bit and one or two stop bits. Each character goes into a sixteen-entry queue, even when its stop or parity bit is wrong. Every entry keeps its own framing and parity tags, and reception carries on with the next character.

The host side acts like a small register file. A pop strobe removes the entry at the head of the queue. The head character and its two tags are always visible, together with the queue level and two 4-bit counts of tagged entries. There are also two sticky flags, one for receive errors and one for overrun. Software clears each flag in two steps: it reads the status while the flag is 1, and then writes a zero. A clear strobe that was not preceded by such a read does nothing.

The line input is assumed to be synchronous to the clock already. Synchronising it is left to the surrounding logic.

Top module: `uart_err_rx`

## Requirements
- R1: After reset, `fifo_level`, `fer_count`, `per_count`, `err_flag` and `ovr_flag` are all 0.
- R2: A character is built from 8 data bits, least significant bit first, and is placed in the queue. While the queue is not empty, `rd_data` shows the oldest character. A `rd_pop` pulse removes that character and lowers `fifo_level` by 1. While the queue is empty, `rd_data`, `head_fer` and `head_per` are 0.
- R3: A low pulse on `rxd` that has ended by the 8th oversampling tick after the falling edge is discarded. No character is stored.
- R4: A character whose first stop bit is sampled as 0 is still stored. Its entry has the framing tag set to 1, and `fer_count` and `err_flag` are updated. Characters that follow are received normally.
- R5: With `two_stop` = 1, the second stop bit is not checked. A 0 in that bit leaves the framing tag at 0.
- R6: With `par_en` = 1, a parity bit follows the data. Even mode is `par_odd` = 0, and odd mode is `par_odd` = 1. If the number of 1s in the data and parity bit together has the wrong sense for the selected mode, the entry gets the parity tag. That entry is counted in `per_count` and also sets `err_flag`.
- R7: `err_flag` stays at 1 until an `err_clr` pulse that follows a `stat_rd` pulse made while the flag was 1. An `err_clr` pulse without such a read leaves the flag at 1.
- R8: While `rx_en` is 0, no character is received and `err_flag` keeps its value.
- R9: `fer_count` is 4 bits wide and counts queue entries that carry the framing tag. When all 16 entries carry it, the count reads 0.
- R10: A character that completes while the queue holds 16 entries is dropped and sets `ovr_flag`. That flag is cleared with the same read-then-`ovr_clr` sequence as `err_flag`.
- R11: `head_fer` and `head_per` show the tags of the head entry, and they change to the next entry's tags on each pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | Two stop bits per character |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read strobe; arms the flag clears |
| err_clr | input | 1 | Write zero to the error flag |
| ovr_clr | input | 1 | Write zero to the overrun flag |
| rd_data | output | 8 | Head character |
| head_fer | output | 1 | Framing tag of the head entry |
| head_per | output | 1 | Parity tag of the head entry |
| fifo_level | output | 5 | Number of stored entries, 0 to 16 |
| fer_count | output | 4 | Entries with the framing tag, modulo 16 |
| per_count | output | 4 | Entries with the parity tag, modulo 16 |
| err_flag | output | 1 | Sticky receive-error flag |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The queue entry, the counts and `err_flag` all change on the clock edge of the oversampling tick that samples the middle of the first stop bit. The bench therefore holds each stop bit for a full bit time, plus a quiet gap, and samples on a falling clock edge well after that update. Pops and flag strobes take effect on the next rising edge. The bench checks their results on the falling edge that follows. For the glitch, disabled-receiver and unarmed-clear cases, it reads the level and the flags at the ports before starting the next stimulus.

// File: rtl/uart_err_rx.sv
module uart_err_rx #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          rd_pop,
  input  logic          stat_rd,
  input  logic          err_clr,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic          head_fer,
  output logic          head_per,
  output logic [AW:0]   fifo_level,
  output logic [AW-1:0] fer_count,
  output logic [AW-1:0] per_count,
  output logic          err_flag,
  output logic          ovr_flag
);
  localparam int EW = DW + 2;
  localparam int BW = $clog2(DW);
  localparam logic [AW:0]   FULLV = (AW+1)'(1 << AW);
  localparam logic [BW-1:0] LASTB = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t           st;
  logic [3:0]    cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic          pbit, line_q;
  logic [EW-1:0] mem [1 << AW];
  logic [AW-1:0] wp, rp;
  logic          arm_err, arm_ovr;

  wire           mid     = tick16 && cnt == 4'd15;
  wire           push    = st == S_STOP1 && mid && rx_en;
  wire           fer_now = !rxd;
  wire           per_now = par_en && ((^sh ^ pbit) ^ par_odd);
  wire           full    = fifo_level == FULLV;
  wire           empty   = fifo_level == '0;
  wire           do_push = push && !full;
  wire           do_pop  = rd_pop && !empty;
  wire [EW-1:0]  head    = mem[rp];

  assign rd_data  = empty ? '0 : head[DW-1:0];
  assign head_fer = !empty && head[DW];
  assign head_per = !empty && head[DW+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '0; pbit <= 1'b0; line_q <= 1'b1;
    end else begin
      if (tick16) line_q <= rxd;
      if (!rx_en) st <= S_IDLE;
      else if (tick16) begin
        cnt <= cnt + 4'd1;
        case (st)
          S_IDLE: if (line_q && !rxd) begin st <= S_START; cnt <= '0; end
          S_START: if (cnt == 4'd6) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxd ? S_IDLE : S_DATA;
          end
          S_DATA: if (cnt == 4'd15) begin
            sh   <= {rxd, sh[DW-1:1]};
            bidx <= bidx + 1'b1;
            if (bidx == LASTB) st <= par_en ? S_PAR : S_STOP1;
          end
          S_PAR: if (cnt == 4'd15) begin pbit <= rxd; st <= S_STOP1; end
          S_STOP1: if (cnt == 4'd15) st <= two_stop ? S_STOP2 : S_IDLE;
          S_STOP2: if (cnt == 4'd15) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {per_now, fer_now, sh};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fifo_level <= '0; fer_count <= '0; per_count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      fifo_level <= fifo_level + (AW+1)'(do_push) - (AW+1)'(do_pop);
      fer_count  <= fer_count + AW'(do_push && fer_now) - AW'(do_pop && head[DW]);
      per_count  <= per_count + AW'(do_push && per_now) - AW'(do_pop && head[DW+1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0; ovr_flag <= 1'b0; arm_err <= 1'b0; arm_ovr <= 1'b0;
    end else begin
      if (push && (fer_now || per_now)) err_flag <= 1'b1;
      else if (err_clr && arm_err)      err_flag <= 1'b0;
      if (push && full)                 ovr_flag <= 1'b1;
      else if (ovr_clr && arm_ovr)      ovr_flag <= 1'b0;
      if (err_clr && arm_err)           arm_err <= 1'b0;
      else if (stat_rd && err_flag)     arm_err <= 1'b1;
      if (ovr_clr && arm_ovr)           arm_ovr <= 1'b0;
      else if (stat_rd && ovr_flag)     arm_ovr <= 1'b1;
    end
  end
endmodule

module uart_err_rx_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_clr,
  input logic          ovr_clr,
  input logic [DW-1:0] rd_data,
  input logic          head_fer,
  input logic          head_per,
  input logic [AW:0]   fifo_level,
  input logic [AW-1:0] fer_count,
  input logic [AW-1:0] per_count,
  input logic          err_flag,
  input logic          ovr_flag
);
  localparam logic [AW:0] FULLV = (AW+1)'(1 << AW);

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!err_flag && !ovr_flag && fifo_level == '0));

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fifo_level == $past(fifo_level) ||
                      fifo_level == $past(fifo_level) + 1'b1 ||
                      fifo_level == $past(fifo_level) - 1'b1));

  p_empty_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level == '0 |-> (rd_data == '0 && !head_fer && !head_per));

  p_err_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(err_clr));

  p_empty_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level == '0 |-> (fer_count == '0 && per_count == '0));

  p_level_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= FULLV);

  p_ovr_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(ovr_clr));
endmodule

bind uart_err_rx uart_err_rx_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_uart_err_rx.sv
module tb_uart_err_rx;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, rx_en = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic rd_pop = 1'b0, stat_rd = 1'b0, err_clr = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic head_fer, head_per, err_flag, ovr_flag;
  logic [4:0] fifo_level;
  logic [3:0] fer_count, per_count;
  logic [1:0] tdiv = 2'd0;
  logic tick16;
  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = tdiv == 2'd3;

  uart_err_rx dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic usep, input logic pb,
                      input logic s1, input logic use2, input logic s2);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (usep) bit_out(pb);
    bit_out(s1);
    if (use2) bit_out(s2);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic pulse_pop();
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic clr_err();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", fifo_level, 0);
    chk("R1 fer_count", fer_count, 0);
    chk("R1 per_count", per_count, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 ovr_flag", ovr_flag, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 0, 0, 1, 0, 0);
    send(8'h3C, 0, 0, 1, 0, 0);
    chk("R2 level two", fifo_level, 2);
    chk("R2 head first", rd_data, 8'hA5);
    pulse_pop();
    chk("R2 head second", rd_data, 8'h3C);
    chk("R2 level after pop", fifo_level, 1);
    pulse_pop();
    chk("R2 level empty", fifo_level, 0);
    chk("R2 empty data", rd_data, 0);
  endtask

  task automatic t_glitch();
    rxd = 1'b0; repeat (16) @(negedge clk);
    rxd = 1'b1; repeat (200) @(negedge clk);
    chk("R3 glitch dropped", fifo_level, 0);
    send(8'h5A, 0, 0, 1, 0, 0);
    chk("R3 next char", rd_data, 8'h5A);
    pulse_pop();
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1, 1, 1, 0, 0);
    send(8'h07, 1, 0, 1, 0, 0);
    par_odd = 1'b1;
    send(8'h07, 1, 0, 1, 0, 0);
    chk("R6 level", fifo_level, 3);
    chk("R6 per_count", per_count, 1);
    chk("R6 err_flag", err_flag, 1);
    chk("R6 good even", head_per, 0);
    pulse_pop();
    chk("R11 bad even tag", head_per, 1);
    chk("R6 bad even data", rd_data, 8'h07);
    pulse_pop();
    chk("R11 good odd tag", head_per, 0);
    chk("R6 per_count after pops", per_count, 0);
    pulse_pop();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_clear();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk("R7 unarmed clear ignored", err_flag, 1);
    clr_err();
    chk("R7 armed clear", err_flag, 0);
  endtask

  task automatic t_frame();
    send(8'h81, 0, 0, 0, 0, 0);
    send(8'h42, 0, 0, 1, 0, 0);
    chk("R4 level", fifo_level, 2);
    chk("R4 data kept", rd_data, 8'h81);
    chk("R4 tag", head_fer, 1);
    chk("R4 fer_count", fer_count, 1);
    chk("R4 err_flag", err_flag, 1);
    pulse_pop();
    chk("R4 next char", rd_data, 8'h42);
    chk("R11 tag cleared", head_fer, 0);
    chk("R4 fer_count after", fer_count, 0);
    pulse_pop();
  endtask

  task automatic t_disable();
    rx_en = 1'b0;
    send(8'h11, 0, 0, 0, 0, 0);
    chk("R8 nothing stored", fifo_level, 0);
    chk("R8 err kept", err_flag, 1);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    clr_err();
  endtask

  task automatic t_two_stop();
    two_stop = 1'b1;
    send(8'h99, 0, 0, 1, 1, 0);
    chk("R5 second stop ignored", head_fer, 0);
    chk("R5 no err", err_flag, 0);
    chk("R5 data", rd_data, 8'h99);
    send(8'h66, 0, 0, 0, 1, 1);
    chk("R5 level", fifo_level, 2);
    pulse_pop();
    chk("R5 first stop checked", head_fer, 1);
    pulse_pop();
    two_stop = 1'b0;
    clr_err();
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) send(8'(i), 0, 0, 0, 0, 0);
    chk("R9 level full", fifo_level, 16);
    chk("R9 count wraps", fer_count, 0);
    chk("R9 head", rd_data, 0);
    send(8'hEE, 0, 0, 1, 0, 0);
    chk("R10 level held", fifo_level, 16);
    chk("R10 ovr_flag", ovr_flag, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    chk("R10 unarmed clear", ovr_flag, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk("R10 armed clear", ovr_flag, 0);
    pulse_pop();
    chk("R9 fer_count 15", fer_count, 15);
    chk("R11 head tag", head_fer, 1);
    for (int i = 1; i < 16; i++) pulse_pop();
    chk("R10 dropped char absent", fifo_level, 0);
    chk("R9 fer_count end", fer_count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_clear();
    t_frame();
    t_disable();
    t_two_stop();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule